// File: doc/BRIEF.md
# Hashed Page Table Entry Encoder

This block assembles the two 64-bit doublewords of a hashed page table entry in one registered step. The first doubleword (the V word) carries the abbreviated virtual page number, the segment size code and a small set of status flags. The second doubleword (the R word) carries the real page number and the protection and storage attributes. The caller supplies a virtual page number that has already been shifted right by 12, a physical address, a segment size code, and a page-size descriptor made of a page shift, a large-page encoding value and an abbreviation mask.

Alongside the encoder sits a matcher. It compares a stored V word against a search key and ignores the low seven bits, which hold per-entry flags. A table walker uses this matcher to find an existing entry. All three results (V word, R word and match flag) are registered together. They appear one clock after a cycle with `enc_valid` high and hold their values while `enc_valid` is low.

Top module: `hpte_encoder`

## Requirements
- R1: After reset `out_valid`, `v_word`, `r_word` and `match` are all zero.
- R2: `out_valid` equals `enc_valid` delayed by one clock. V word, R word and match change only one clock after a cycle with `enc_valid` high, and hold otherwise.
- R3: V word bits 61:7 equal (`vpn` shifted right by 11) with every bit set in `avpn_mask` forced to zero.
- R4: V word bits 63:62 equal `seg_size`.
- R5: V word flag layout: bit 0 is `pte_valid`, bit 1 is `secondary`, bit 4 is `bolted`, bit 3 (the lock bit) is always 0, and bits 6:5 are 0.
- R6: V word bit 2 (large) is 1 exactly when `pg_shift` differs from 12, the base 4 KB page shift.
- R7: When `pg_shift` is 12, the address part of the R word is `pa` AND 0x0FFF_FFFF_FFFF_F000.
- R8: When `pg_shift` is not 12 (valid values are 13 to 63), the address part of the R word is `pa` with its low `pg_shift` bits cleared, ORed with `pg_lp` shifted left by 12.
- R9: The attribute inputs are ORed into the encoded address: `pp` into bits 1:0, `no_exec` into bit 2, `wimg` into bits 6:3 and `pp0` into bit 63. Bits 7 (changed) and 8 (referenced) come only from the address part.
- R10: `match` is 1 exactly when `cmp_stored` and `cmp_key` are equal in bits 63:7. Bits 6:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enc_valid | input | 1 | Capture enable for the encode and compare inputs |
| vpn | input | 64 | Virtual page number, already shifted right by 12 |
| pa | input | 64 | Physical address, aligned to the page size |
| seg_size | input | 2 | Segment size code |
| pg_shift | input | 6 | Page shift of the page size (12 means 4 KB) |
| pg_lp | input | 8 | Large-page encoding value |
| avpn_mask | input | 55 | Abbreviated page number bits to clear for this page size |
| pte_valid | input | 1 | Entry valid flag |
| secondary | input | 1 | Entry placed by the secondary hash |
| bolted | input | 1 | Entry is bolted |
| pp | input | 2 | Page protection bits |
| pp0 | input | 1 | Extended page protection bit |
| no_exec | input | 1 | No-execute attribute |
| wimg | input | 4 | Storage attributes |
| cmp_stored | input | 64 | Stored V word for comparison |
| cmp_key | input | 64 | V word search key |
| out_valid | output | 1 | Registered outputs updated in the previous cycle |
| v_word | output | 64 | Encoded first doubleword |
| r_word | output | 64 | Encoded second doubleword |
| match | output | 1 | Compare result for the last captured pair |

## Verification
The hardest case to reach is where the large-page address clearing and the encoding value overlap. This happens when `pg_lp` has bits that land inside the cleared low part of the address, and when the abbreviation mask cuts into the abbreviated page number. Random stimulus rarely produces both at once, so the stimulus forces them. It steps through page shifts of 12, 13, 16, 24 and 34, with all-ones addresses and all-ones encoding values. For the matcher, it drives key pairs that differ only in bits 6:0 and pairs that differ only in bit 7.

// File: rtl/hpte_pkg.sv
package hpte_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned BASE_SHIFT = 12;
  localparam int unsigned AVPN_DROP  = 11;
  localparam int unsigned AVPN_LSB   = 7;
  localparam int unsigned SEG_W      = 2;
  localparam int unsigned AVPN_W     = WORD_W - SEG_W - AVPN_LSB;
  localparam int unsigned LP_POS     = 12;

  typedef struct packed {
    logic       pp0;
    logic       no_exec;
    logic [3:0] wimg;
    logic [1:0] pp;
  } hpte_prot_t;
endpackage

// File: rtl/hpte_v_build.sv
module hpte_v_build
  import hpte_pkg::*;
(
  input  logic [WORD_W-1:0] vpn,
  input  logic [AVPN_W-1:0] avpn_mask,
  input  logic [SEG_W-1:0]  seg_size,
  input  logic              is_large,
  input  logic              pte_valid,
  input  logic              secondary,
  input  logic              bolted,
  output logic [WORD_W-1:0] v_word
);
  logic [AVPN_W-1:0] avpn_raw;
  logic [AVPN_W-1:0] avpn_kept;

  always_comb begin
    avpn_raw  = AVPN_W'(vpn >> AVPN_DROP);
    avpn_kept = avpn_raw & ~avpn_mask;
    v_word    = {seg_size, avpn_kept, 2'b00, bolted, 1'b0, is_large,
                 secondary, pte_valid};
  end
endmodule

// File: rtl/hpte_r_build.sv
module hpte_r_build
  import hpte_pkg::*;
#(
  parameter int unsigned LP_W = 8
) (
  input  logic [WORD_W-1:0] pa,
  input  logic [5:0]        pg_shift,
  input  logic [LP_W-1:0]   pg_lp,
  input  logic              is_large,
  input  hpte_prot_t        prot,
  output logic [WORD_W-1:0] r_word
);
  localparam logic [WORD_W-1:0] RPN_MASK = 64'h0FFF_FFFF_FFFF_F000;

  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] addr_part;
  logic [WORD_W-1:0] attr_part;

  always_comb begin
    keep_mask = ~((WORD_W'(1) << pg_shift) - WORD_W'(1));
    if (is_large)
      addr_part = (pa & keep_mask) | (WORD_W'(pg_lp) << LP_POS);
    else
      addr_part = pa & RPN_MASK;
    attr_part = {prot.pp0, 56'd0, prot.wimg, prot.no_exec, prot.pp};
    r_word    = addr_part | attr_part;
  end
endmodule

// File: rtl/hpte_v_match.sv
module hpte_v_match
  import hpte_pkg::*;
(
  input  logic [WORD_W-1:0] stored,
  input  logic [WORD_W-1:0] key,
  output logic              hit
);
  logic [WORD_W-1:0] diff;

  always_comb begin
    diff = (stored ^ key) >> AVPN_LSB;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/hpte_encoder.sv
module hpte_encoder
  import hpte_pkg::*;
#(
  parameter int unsigned LP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid,
  input  logic [63:0]       vpn,
  input  logic [63:0]       pa,
  input  logic [1:0]        seg_size,
  input  logic [5:0]        pg_shift,
  input  logic [LP_W-1:0]   pg_lp,
  input  logic [54:0]       avpn_mask,
  input  logic              pte_valid,
  input  logic              secondary,
  input  logic              bolted,
  input  logic [1:0]        pp,
  input  logic              pp0,
  input  logic              no_exec,
  input  logic [3:0]        wimg,
  input  logic [63:0]       cmp_stored,
  input  logic [63:0]       cmp_key,
  output logic              out_valid,
  output logic [63:0]       v_word,
  output logic [63:0]       r_word,
  output logic              match
);
  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              large_sel;
  hpte_prot_t        prot;
  logic [WORD_W-1:0] v_enc, r_enc;
  logic              hit_enc;

  assign large_sel = (pg_shift != 6'(BASE_SHIFT));
  assign prot      = '{pp0: pp0, no_exec: no_exec, wimg: wimg, pp: pp};

  hpte_v_build u_vbuild (
    .vpn(vpn), .avpn_mask(avpn_mask), .seg_size(seg_size), .is_large(large_sel),
    .pte_valid(pte_valid), .secondary(secondary), .bolted(bolted), .v_word(v_enc)
  );

  hpte_r_build #(.LP_W(LP_W)) u_rbuild (
    .pa(pa), .pg_shift(pg_shift), .pg_lp(pg_lp), .is_large(large_sel),
    .prot(prot), .r_word(r_enc)
  );

  hpte_v_match u_match (.stored(cmp_stored), .key(cmp_key), .hit(hit_enc));

  // next-state process with explicit capture enable
  logic              valid_d;
  logic [WORD_W-1:0] v_d, r_d;
  logic              match_d;

  always_comb begin
    valid_d = enc_valid;
    v_d     = v_word;
    r_d     = r_word;
    match_d = match;
    if (enc_valid) begin
      v_d     = v_enc;
      r_d     = r_enc;
      match_d = hit_enc;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      v_word    <= '0;
      r_word    <= '0;
      match     <= 1'b0;
    end else begin
      out_valid <= valid_d;
      v_word    <= v_d;
      r_word    <= r_d;
      match     <= match_d;
    end
  end

  assert_valid_pipe_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    enc_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enc_valid |=> (!out_valid && $stable(v_word) && $stable(r_word) && $stable(match)));
  assert_seg_code_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    enc_valid |=> (v_word[63:62] == $past(seg_size)));
  assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    enc_valid |=> (v_word[0] == $past(pte_valid) && v_word[1] == $past(secondary) &&
                   v_word[4] == $past(bolted) && v_word[3] == 1'b0));
  assert_large_flag_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    enc_valid |=> (v_word[2] == ($past(pg_shift) != 6'd12)));
  assert_prot_low_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    enc_valid |=> (r_word[1:0] == $past(pp) && r_word[6:3] == $past(wimg) &&
                   r_word[2] == $past(no_exec)));
  assert_key_equal_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enc_valid && cmp_stored == cmp_key) |=> match);
endmodule

// File: tb/hpte_encoder_bench.sv
module hpte_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_valid;
  logic [63:0] vpn, pa, cmp_stored, cmp_key;
  logic [1:0]  seg_size, pp;
  logic [5:0]  pg_shift;
  logic [7:0]  pg_lp;
  logic [54:0] avpn_mask;
  logic        pte_valid, secondary, bolted, pp0, no_exec;
  logic [3:0]  wimg;
  logic        out_valid, match;
  logic [63:0] v_word, r_word;

  always #4 clk = ~clk;

  hpte_encoder u_hpte_encoder (
    .clk(clk), .rst_n(rst_n), .enc_valid(enc_valid), .vpn(vpn), .pa(pa),
    .seg_size(seg_size), .pg_shift(pg_shift), .pg_lp(pg_lp), .avpn_mask(avpn_mask),
    .pte_valid(pte_valid), .secondary(secondary), .bolted(bolted), .pp(pp),
    .pp0(pp0), .no_exec(no_exec), .wimg(wimg), .cmp_stored(cmp_stored),
    .cmp_key(cmp_key), .out_valid(out_valid), .v_word(v_word), .r_word(r_word),
    .match(match)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic        e_ov, e_m;
  logic [63:0] e_v, e_r;
  logic        large_q;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: update expectations from the inputs just applied
  task automatic model_capture();
    logic [63:0] ab, addr, attr, keep;
    e_ov = enc_valid;
    if (enc_valid) begin
      ab = (vpn / 64'd2048) & ~{9'd0, avpn_mask};
      ab = ab % (64'd1 << 55);
      large_q = (pg_shift != 6'd12);
      e_v = (64'(seg_size) * (64'd1 << 62)) + ab * 64'd128 + 64'(bolted) * 16
            + 64'(large_q) * 4 + 64'(secondary) * 2 + 64'(pte_valid);
      if (!large_q) addr = pa & 64'h0FFF_FFFF_FFFF_F000;
      else begin
        keep = pa - (pa % (64'd1 << pg_shift));
        addr = keep | (64'(pg_lp) * 64'd4096);
      end
      attr = 64'(pp) | (64'(no_exec) * 4) | (64'(wimg) * 8) | (64'(pp0) << 63);
      e_r = addr | attr;
      e_m = ((cmp_stored / 128) == (cmp_key / 128));
    end
  endtask

  task automatic compare_all();
    check("R2 out_valid", 64'(out_valid), 64'(e_ov));
    check("R4 seg code", 64'(v_word[63:62]), 64'(e_v[63:62]));
    check("R3 avpn", 64'(v_word[61:7]), 64'(e_v[61:7]));
    check("R5 flags", 64'(v_word[6:0] & 7'h7B), 64'(e_v[6:0] & 7'h7B));
    check("R6 large", 64'(v_word[2]), 64'(e_v[2]));
    if (large_q) check("R8 large r word", r_word, e_r);
    else         check("R7 base r word", r_word, e_r);
    check("R9 attr bits", {r_word[63], 54'd0, r_word[8:0]}, {e_r[63], 54'd0, e_r[8:0]});
    check("R10 match", 64'(match), 64'(e_m));
  endtask

  task automatic step();
    model_capture();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_enc(input logic [63:0] v, input logic [63:0] p, input logic [5:0] sh,
                         input logic [7:0] lp, input logic [54:0] m);
    enc_valid = 1'b1; vpn = v; pa = p; pg_shift = sh; pg_lp = lp; avpn_mask = m;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enc_valid = 1'b0; vpn = '0; pa = '0; seg_size = '0; pg_shift = 6'd12;
    pg_lp = '0; avpn_mask = '0; pte_valid = 0; secondary = 0; bolted = 0; pp = 0;
    pp0 = 0; no_exec = 0; wimg = 0; cmp_stored = '0; cmp_key = '0;
    e_ov = 0; e_m = 0; e_v = '0; e_r = '0; large_q = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 v_word", v_word, 64'd0);
    check("R1 r_word", r_word, 64'd0);
    check("R1 match", 64'(match), 64'd0);

    // directed: base page, all-ones address
    seg_size = 2'd1; pte_valid = 1; bolted = 1; pp = 2'd2; wimg = 4'b0101;
    set_enc(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd12, 8'hFF, '0);
    cmp_stored = 64'h1234_5678_9ABC_DE80; cmp_key = 64'h1234_5678_9ABC_DEFF;
    step();
    // large shifts with overlapping encoding value
    foreach (sh_list[i]) begin
      set_enc(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, sh_list[i], 8'hFF,
              55'h7F_FFFF);
      pp0 = i[0]; secondary = i[1]; no_exec = ~i[0];
      cmp_key = cmp_stored ^ 64'h80;
      step();
    end
    // idle cycles hold outputs (R2)
    enc_valid = 1'b0; vpn = 64'h5555; pa = 64'hAAAA_0000; cmp_key = cmp_stored;
    step(); step();
    // random patterns
    for (int k = 0; k < 400; k++) begin
      enc_valid = ($urandom_range(0, 3) != 0);
      vpn = {$urandom(), $urandom()};
      pa = {$urandom(), $urandom()};
      seg_size = 2'($urandom());
      pg_shift = sh_list[$urandom_range(0, 4)];
      pg_lp = 8'($urandom());
      avpn_mask = 55'(({$urandom(), $urandom()}) & ((64'd1 << $urandom_range(0, 20)) - 1));
      pte_valid = 1'($urandom()); secondary = 1'($urandom()); bolted = 1'($urandom());
      pp = 2'($urandom()); pp0 = 1'($urandom()); no_exec = 1'($urandom());
      wimg = 4'($urandom());
      cmp_stored = {$urandom(), $urandom()};
      case ($urandom_range(0, 2))
        0: cmp_key = cmp_stored ^ 64'(7'($urandom()));
        1: cmp_key = cmp_stored ^ (64'd1 << $urandom_range(7, 63));
        default: cmp_key = {$urandom(), $urandom()};
      endcase
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  logic [5:0] sh_list [5] = '{6'd12, 6'd13, 6'd16, 6'd24, 6'd34};
endmodule